// File: doc/BRIEF.md
# Effective Address Generator

This unit is the combinational address path of a small 16-bit load/store datapath. From the instruction word, the already-incremented program counter and one base register value, it forms the target address used by loads, stores and branches. It also forms the value that goes to the memory address register. A two-bit mode select picks one of four ways to build the address:
- a 9-bit signed offset added to the PC;
- a 6-bit signed offset added to a base register;
- a 9-bit signed offset added to zero;
- an 8-bit service vector, zero-extended, that goes to the memory address register only.

Internally, a small control decoder turns the mode into a set of select strobes. A datapath uses those strobes to choose the adder operands and the memory-address source. The unit also presents the 3-bit base register index taken from the instruction, so that the register file can be read in the same cycle. Reading the register file and timing the memory are left to the surrounding logic.

Top module: `eag_top`

## Requirements
- R1: With `modeSel` = 2'b00, `addrOut` equals `pcNext` plus `instrWord[8:0]` sign-extended to 16 bits.
- R2: With `modeSel` = 2'b01, `addrOut` equals `baseVal` plus `instrWord[5:0]` sign-extended to 16 bits.
- R3: With `modeSel` = 2'b10, `addrOut` equals `instrWord[8:0]` sign-extended to 16 bits, which is the same as adding the offset to a base of zero.
- R4: With `modeSel` = 2'b11, `marOut` equals `{8'h00, instrWord[7:0]}` and `addrOut` is 16'h0000.
- R5: For mode select values 2'b00, 2'b01 and 2'b10, `marOut` equals `addrOut`.
- R6: `baseIdx` always equals `instrWord[8:6]`, whatever the mode.
- R7: Every sum wraps modulo 2^16 and no overflow indication exists. For example, 16'hFFFF plus 1 gives 16'h0000.
- R8: In PC-relative mode the reachable range runs from `pcNext`-256 (offset 9'h100) to `pcNext`+255 (offset 9'h0FF).
- R9: Instruction bits that lie outside the field the current mode uses have no effect on `addrOut` or `marOut`. These include the opcode `instrWord[15:12]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 16 | Current instruction word |
| pcNext | input | 16 | Program counter, already incremented |
| baseVal | input | 16 | Value read from the base register |
| modeSel | input | 2 | 00 PC+off9, 01 base+off6, 10 zero+off9, 11 vector |
| addrOut | output | 16 | Adder result: memory or branch target |
| marOut | output | 16 | Value for the memory address register |
| baseIdx | output | 3 | Base register index, instrWord[8:6] |

## Verification
The unit holds no state, so any wrong select strobe or wrong extension appears at `addrOut` or `marOut` in the same cycle as the input that exposes it. A strobe decoded from the wrong mode shows up as the wrong base operand. Examples are the PC appearing where zero belongs, or a vector reaching the memory address register in an adder mode. Offsets near the sign boundary and sums that wrap around the top of the address space are where extension and width faults become visible. Varying the opcode bits and the unused field bits while the used fields stay fixed shows whether a field slice has been misplaced.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    MODE_PC_OFF9   = 2'b00,
    MODE_BASE_OFF6 = 2'b01,
    MODE_ZERO_OFF9 = 2'b10,
    MODE_VECTOR    = 2'b11
  } eag_mode_e;

  // select strobes from the decoder to the datapath
  typedef struct packed {
    logic pickPc;      // adder base is the incremented PC
    logic pickReg;     // adder base is the base register
    logic takeLong;    // adder offset is the long (9-bit) field
    logic takeShort;   // adder offset is the short (6-bit) field
    logic marFromVec;  // MAR takes the zero-extended vector
  } eag_strobe_t;

endpackage

// File: rtl/eag_field_ext.sv
module eag_field_ext #(
  parameter int FIELD_W  = 9,
  parameter int OUT_W    = 16,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic [FIELD_W-1:0] fieldIn,
  output logic [OUT_W-1:0]   extOut
);
  localparam int PAD_W = OUT_W - FIELD_W;

  generate
    if (SIGN_EXT) begin : g_sign
      assign extOut = {{PAD_W{fieldIn[FIELD_W-1]}}, fieldIn};
    end else begin : g_zero
      assign extOut = {{PAD_W{1'b0}}, fieldIn};
    end
  endgenerate
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int REG_IDX_W = 3
) (
  input  logic [1:0]           modeSel,
  input  logic [REG_IDX_W-1:0] regField,
  output eag_strobe_t          strobes,
  output logic [REG_IDX_W-1:0] baseIdx
);
  eag_mode_e mode;

  assign mode    = eag_mode_e'(modeSel);
  assign baseIdx = regField;

  always_comb begin
    strobes = '0;
    unique case (mode)
      MODE_PC_OFF9: begin
        strobes.pickPc   = 1'b1;
        strobes.takeLong = 1'b1;
      end
      MODE_BASE_OFF6: begin
        strobes.pickReg   = 1'b1;
        strobes.takeShort = 1'b1;
      end
      MODE_ZERO_OFF9: begin
        strobes.takeLong = 1'b1;
      end
      MODE_VECTOR: begin
        strobes.marFromVec = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // at most one base source and one offset source at a time (R3, R4)
  always_comb begin
    assert_single_base_R3: assert ($onehot0({strobes.pickPc, strobes.pickReg}))
      else $error("two adder bases selected");
    assert_single_off_R3: assert ($onehot0({strobes.takeLong, strobes.takeShort}))
      else $error("two offsets selected");
    if (strobes.marFromVec)
      assert_vec_quiet_R4: assert (!strobes.pickPc && !strobes.pickReg && !strobes.takeLong && !strobes.takeShort)
        else $error("adder active on vector path");
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LONG_W  = 9,
  parameter int SHORT_W = 6,
  parameter int VEC_W   = 8
) (
  input  logic [LONG_W-1:0] longField,
  input  logic [SHORT_W-1:0] shortField,
  input  logic [VEC_W-1:0]  vecField,
  input  logic [WORD_W-1:0] pcNext,
  input  logic [WORD_W-1:0] baseVal,
  input  eag_strobe_t       strobes,
  output logic [WORD_W-1:0] addrOut,
  output logic [WORD_W-1:0] marOut
);
  logic [WORD_W-1:0] longExt, shortExt, vecExt;
  logic [WORD_W-1:0] baseOperand, offOperand;

  eag_field_ext #(.FIELD_W(LONG_W), .OUT_W(WORD_W), .SIGN_EXT(1'b1)) u_extLong (
    .fieldIn(longField), .extOut(longExt));
  eag_field_ext #(.FIELD_W(SHORT_W), .OUT_W(WORD_W), .SIGN_EXT(1'b1)) u_extShort (
    .fieldIn(shortField), .extOut(shortExt));
  eag_field_ext #(.FIELD_W(VEC_W), .OUT_W(WORD_W), .SIGN_EXT(1'b0)) u_extVec (
    .fieldIn(vecField), .extOut(vecExt));

  always_comb begin
    baseOperand = '0;
    if (strobes.pickPc)       baseOperand = pcNext;
    else if (strobes.pickReg) baseOperand = baseVal;
  end

  always_comb begin
    offOperand = '0;
    if (strobes.takeLong)       offOperand = longExt;
    else if (strobes.takeShort) offOperand = shortExt;
  end

  // modulo 2^WORD_W, carry discarded
  assign addrOut = baseOperand + offOperand;
  assign marOut  = strobes.marFromVec ? vecExt : addrOut;

  always_comb begin
    if (!strobes.marFromVec)
      assert_mar_follows_R5: assert (marOut == addrOut)
        else $error("MAR differs from adder in adder mode");
    if (!strobes.pickPc && !strobes.pickReg)
      assert_zero_base_R3: assert (addrOut == offOperand)
        else $error("zero base not zero");
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LONG_W    = 9,
  parameter int SHORT_W   = 6,
  parameter int VEC_W     = 8,
  parameter int REG_IDX_W = 3,
  parameter int REG_LSB   = 6
) (
  input  logic [WORD_W-1:0]    instrWord,
  input  logic [WORD_W-1:0]    pcNext,
  input  logic [WORD_W-1:0]    baseVal,
  input  logic [1:0]           modeSel,
  output logic [WORD_W-1:0]    addrOut,
  output logic [WORD_W-1:0]    marOut,
  output logic [REG_IDX_W-1:0] baseIdx
);
  eag_strobe_t strobes;

  eag_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .modeSel (modeSel),
    .regField(instrWord[REG_LSB +: REG_IDX_W]),
    .strobes (strobes),
    .baseIdx (baseIdx)
  );

  eag_datapath #(
    .WORD_W(WORD_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .VEC_W(VEC_W)
  ) u_dp (
    .longField (instrWord[LONG_W-1:0]),
    .shortField(instrWord[SHORT_W-1:0]),
    .vecField  (instrWord[VEC_W-1:0]),
    .pcNext    (pcNext),
    .baseVal   (baseVal),
    .strobes   (strobes),
    .addrOut   (addrOut),
    .marOut    (marOut)
  );

  // port-level relations, independent of the internal strobe structure
  always_comb begin
    if (modeSel == 2'b00)
      assert_pc_rel_R1: assert (addrOut == pcNext + {{(WORD_W-LONG_W){instrWord[LONG_W-1]}}, instrWord[LONG_W-1:0]})
        else $error("PC-relative address wrong");
    if (modeSel == 2'b01)
      assert_base_off_R2: assert (addrOut == baseVal + {{(WORD_W-SHORT_W){instrWord[SHORT_W-1]}}, instrWord[SHORT_W-1:0]})
        else $error("base+offset address wrong");
    if (modeSel == 2'b11)
      assert_vector_R4: assert (marOut == {{(WORD_W-VEC_W){1'b0}}, instrWord[VEC_W-1:0]} && addrOut == '0)
        else $error("vector path wrong");
    assert_reg_idx_R6: assert (baseIdx == instrWord[REG_LSB +: REG_IDX_W])
      else $error("base index wrong");
  end
endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [15:0] instrWord, pcNext, baseVal;
  logic [1:0]  modeSel;
  logic [15:0] addrOut, marOut;
  logic [2:0]  baseIdx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  eag_top dut (
    .instrWord(instrWord), .pcNext(pcNext), .baseVal(baseVal), .modeSel(modeSel),
    .addrOut(addrOut), .marOut(marOut), .baseIdx(baseIdx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(output int expAddr, output int expMar, output int expIdx);
    int off9, off6;
    off9 = int'(instrWord[8:0]);
    if (off9 >= 256) off9 -= 512;
    off6 = int'(instrWord[5:0]);
    if (off6 >= 32) off6 -= 64;
    case (modeSel)
      2'd0: expAddr = (int'(pcNext) + off9) & 16'hFFFF;
      2'd1: expAddr = (int'(baseVal) + off6) & 16'hFFFF;
      2'd2: expAddr = off9 & 16'hFFFF;
      default: expAddr = 0;
    endcase
    expMar = (modeSel == 2'd3) ? int'(instrWord[7:0]) : expAddr;
    expIdx = int'(instrWord[8:6]);
  endtask

  // drive after a rising edge, compare at the following falling edge
  task automatic apply(input logic [15:0] ir, input logic [15:0] pc, input logic [15:0] bv,
                       input logic [1:0] md, input string tag);
    int ea, em, ei;
    @(posedge clk);
    #1;
    instrWord = ir; pcNext = pc; baseVal = bv; modeSel = md;
    @(negedge clk);
    model(ea, em, ei);
    check({tag, " addr"}, int'(addrOut), ea);
    check({tag, " mar R5"}, int'(marOut), em);
    check({tag, " idx R6"}, int'(baseIdx), ei);
  endtask

  initial begin
    instrWord = '0; pcNext = '0; baseVal = '0; modeSel = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("quiet R1", int'(addrOut), 0);
    check("quiet R5", int'(marOut), 0);

    apply(16'hE3FD, 16'h30F7, 16'h0000, 2'b00, "R1 pc-3");
    check("R1 literal", int'(addrOut), 16'h30F4);
    apply(16'h644E, 16'h0000, 16'h30F4, 2'b01, "R2 base+14");
    check("R2 literal", int'(addrOut), 16'h3102);
    check("R6 literal", int'(baseIdx), 1);
    apply(16'h6460, 16'h0000, 16'h0040, 2'b01, "R2 neg32");
    check("R2 neg", int'(addrOut), 16'h0020);
    apply(16'h21FF, 16'h4000, 16'h1234, 2'b10, "R3 zero-1");
    check("R3 literal", int'(addrOut), 16'hFFFF);
    apply(16'hF025, 16'h3000, 16'h5555, 2'b11, "R4 vec");
    check("R4 mar", int'(marOut), 16'h0025);
    check("R4 addr", int'(addrOut), 0);
    apply(16'h0001, 16'hFFFF, 16'h0000, 2'b00, "R7 wrap pc");
    check("R7 pc wrap", int'(addrOut), 0);
    apply(16'h001F, 16'h0000, 16'hFFFE, 2'b01, "R7 wrap base");
    check("R7 base wrap", int'(addrOut), 16'h001D);
    apply(16'h0100, 16'h3000, 16'h0000, 2'b00, "R8 low");
    check("R8 low", int'(addrOut), 16'h2F00);
    apply(16'h00FF, 16'h3000, 16'h0000, 2'b00, "R8 high");
    check("R8 high", int'(addrOut), 16'h30FF);
    apply(16'hFE4E, 16'h0000, 16'h30F4, 2'b01, "R9 opc base");
    check("R9 base upper bits", int'(addrOut), 16'h3102);
    apply(16'h1FFD, 16'h30F7, 16'h0000, 2'b00, "R9 opc pc");
    check("R9 pc upper bits", int'(addrOut), 16'h30F4);
    apply(16'h7F25, 16'h3000, 16'h5555, 2'b11, "R9 opc vec");
    check("R9 vec upper bits", int'(marOut), 16'h0025);

    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int n = 0; n < 300; n++) begin
        logic [15:0] a, b, c;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; a = lfsr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; b = lfsr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; c = lfsr;
        apply(a, b, c, lfsr[1:0], "R1 R2 R3 R4 sweep");
      end
    end
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule